// File: doc/BRIEF.md
# Interleaved Three-Timer Register File

This block is the software-visible register store shared by three timer channels. A simple word-addressed bus (address, write data, write strobe, read strobe, read data) reaches eleven register kinds per channel: clock control, counter control, count value, interval, three match values, interrupt status, interrupt enable, event control and event count. The three copies of one kind sit in consecutive words, so the word index divided by three gives the kind and the remainder gives the channel.

The channels' counting logic lives outside. It takes the stored configuration from flat output vectors and returns its live count and event count, which read back unchanged. It also returns six one-cycle event strobes per channel. These strobes set sticky interrupt status bits. Each channel drives one interrupt line, high while any status bit is set together with its enable bit. A status read returns the bits and clears them. A strobe that lands in the same cycle as that read is kept.

Top module: `tri_timer_regs`

## Requirements
- R1: After a synchronous active-low reset, every stored register reads zero except counter control, which reads 0x21. All interrupt lines are low and read data is zero.
- R2: For a word-aligned byte address A, let W = A/4. When W < 33, the register kind is W/3 and the channel is W mod 3. Kinds, in order from 0, are: clock control, counter control, count value, interval, match 1, match 2, match 3, interrupt status, interrupt enable, event control, event count. Writes to a stored kind reach only the selected channel.
- R3: Writes keep only the low bits of write data: 6 bits for clock control, counter control and interrupt enable, 16 bits for interval and the three matches, 3 bits for event control. Reads return these bits zero-extended.
- R4: Count value and event count reads return the selected channel's 16-bit input zero-extended. Writes to these kinds have no effect.
- R5: Strobe bit b of a channel (bit 0 interval, bits 1 to 3 matches 1 to 3, bit 4 overflow, bit 5 event) sets status bit b at the next clock edge. Status bits stay set until cleared.
- R6: Reading a channel's interrupt status returns its value before the read and clears it to zero. Writes to interrupt status have no effect.
- R7: A strobe bit high in the same cycle as a clearing status read is set in the status after that read.
- R8: Each channel's interrupt line is high exactly when its status AND its enable is nonzero. It follows register changes with no extra delay.
- R9: Addresses with W >= 33 read as zero. Writes to them change no register.
- R10: Read data is registered: it shows the addressed value one cycle after the read strobe and holds its last value while no read is made.
- R11: The configuration outputs always equal the stored clock control, counter control, interval, match and event control registers of each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, low two bits ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| ch_count | input | 3*CNT_W | Live count per channel, channel 0 in the low slice |
| ch_event | input | 3*CNT_W | Event count per channel |
| ch_strobe | input | 3*6 | Event strobes, six per channel |
| irq | output | 3 | Interrupt line per channel |
| cfg_clkctl | output | 3*6 | Clock control per channel |
| cfg_cntctl | output | 3*6 | Counter control per channel |
| cfg_interval | output | 3*CNT_W | Interval per channel |
| cfg_match | output | 9*CNT_W | Matches, slice (channel*3+match) |
| cfg_evctl | output | 3*3 | Event control per channel |

## Verification
The clearing read of interrupt status and the setting of status by a channel strobe can fall in the same clock cycle. The bench provokes this with a directed case: one bit is made pending, then the status is read while a different strobe bit is driven. The read must return only the old bit, and a second read must return only the new one. Random traffic then drives strobes on about a third of all cycles while reads land on status words. The bench model clears status on the read before merging that cycle's strobes, and every read result and interrupt line is judged against it.

// File: rtl/ttr_pkg.sv
// Package: shared constants and the register-kind encoding for the
// interleaved three-timer register file.
package ttr_pkg;
    localparam int unsigned NCH    = 3;    // timer channels
    localparam int unsigned NMATCH = 3;    // match registers per channel
    localparam int unsigned NKIND  = 11;   // register kinds per channel
    localparam int unsigned CLK_W  = 6;    // clock control width
    localparam int unsigned CTRL_W = 6;    // counter control width
    localparam int unsigned STAT_W = 6;    // status / enable width
    localparam int unsigned EVC_W  = 3;    // event control width
    localparam logic [CTRL_W-1:0] CTRL_RST = 6'h21;

    // Order is behaviour: kind index = word index / NCH
    typedef enum logic [3:0] {
        K_CLK   = 4'd0,
        K_CTRL  = 4'd1,
        K_VALUE = 4'd2,
        K_INTV  = 4'd3,
        K_M1    = 4'd4,
        K_M2    = 4'd5,
        K_M3    = 4'd6,
        K_STAT  = 4'd7,
        K_EN    = 4'd8,
        K_EVC   = 4'd9,
        K_EVENT = 4'd10,
        K_NONE  = 4'd15
    } kind_e;
endpackage

// File: rtl/ttr_decode.sv
// Address decoder: splits the word index into register kind and channel.
// Assumes word-aligned accesses; the low two address bits are ignored.
// Word indices beyond NCH*NKIND decode to K_NONE.
module ttr_decode
    import ttr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output logic [CH_W-1:0]   chan
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned LIMIT = NCH * NKIND;

    logic [IDX_W-1:0] idx;
    int unsigned      idx_i;

    // Divide the word index by the channel count: quotient kind, remainder channel
    always_comb begin
        idx   = addr[ADDR_W-1:2];
        idx_i = 32'(idx);
        kind  = K_NONE;
        chan  = '0;
        if (idx_i < LIMIT) begin
            kind = kind_e'(4'(idx_i / NCH));
            chan = CH_W'(idx_i % NCH);
        end
    end
endmodule

// File: rtl/ttr_chan.sv
// One channel's register slice: configuration registers, sticky interrupt
// status with clear-on-read, interrupt enable and the interrupt line.
// Assumes wr_hit and clr_hit are already qualified with this channel.
module ttr_chan
    import ttr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  kind_e                    wr_kind,
    input  logic                     wr_hit,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     clr_hit,
    input  logic [STAT_W-1:0]        strobe,
    output logic [CLK_W-1:0]         clk_reg,
    output logic [CTRL_W-1:0]        ctrl_reg,
    output logic [CNT_W-1:0]         intv_reg,
    output logic [NMATCH*CNT_W-1:0]  match_reg,
    output logic [STAT_W-1:0]        stat_reg,
    output logic [STAT_W-1:0]        en_reg,
    output logic [EVC_W-1:0]         evc_reg,
    output logic                     irq
);
    // Write port for the scalar configuration registers, masked to width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_reg  <= '0;
            ctrl_reg <= CTRL_RST;
            intv_reg <= '0;
            en_reg   <= '0;
            evc_reg  <= '0;
        end else if (wr_hit) begin
            case (wr_kind)
                K_CLK:   clk_reg  <= wdata[CLK_W-1:0];
                K_CTRL:  ctrl_reg <= wdata[CTRL_W-1:0];
                K_INTV:  intv_reg <= wdata[CNT_W-1:0];
                K_EN:    en_reg   <= wdata[STAT_W-1:0];
                K_EVC:   evc_reg  <= wdata[EVC_W-1:0];
                default: ;
            endcase
        end
    end

    // One register per match slot
    for (genvar m = 0; m < NMATCH; m++) begin : g_match
        logic [CNT_W-1:0] mreg;

        // Match register write, selected by consecutive kind codes
        always_ff @(posedge clk) begin
            if (!rst_n)
                mreg <= '0;
            else if (wr_hit && (int'(wr_kind) == int'(K_M1) + m))
                mreg <= wdata[CNT_W-1:0];
        end

        assign match_reg[m*CNT_W +: CNT_W] = mreg;
    end

    // Sticky status: a read clears, same-cycle strobes are merged after the clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_reg <= '0;
        else
            stat_reg <= (clr_hit ? '0 : stat_reg) | strobe;
    end

    // Interrupt line: any enabled pending bit
    assign irq = |(stat_reg & en_reg);
endmodule

// File: rtl/ttr_rdmux.sv
// Read multiplexer: picks the addressed channel's register of the decoded
// kind and zero-extends it to the bus width. Purely combinational.
module ttr_rdmux
    import ttr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CH_W   = 2
) (
    input  kind_e                          kind,
    input  logic [CH_W-1:0]                chan,
    input  logic [NCH*CLK_W-1:0]           clk_all,
    input  logic [NCH*CTRL_W-1:0]          ctrl_all,
    input  logic [NCH*CNT_W-1:0]           intv_all,
    input  logic [NCH*NMATCH*CNT_W-1:0]    match_all,
    input  logic [NCH*STAT_W-1:0]          stat_all,
    input  logic [NCH*STAT_W-1:0]          en_all,
    input  logic [NCH*EVC_W-1:0]           evc_all,
    input  logic [NCH*CNT_W-1:0]           count_all,
    input  logic [NCH*CNT_W-1:0]           event_all,
    output logic [DATA_W-1:0]              rd_val
);
    int c;
    int m;

    // Select by kind, then slice by channel
    always_comb begin
        rd_val = '0;
        c      = int'(chan);
        m      = 0;
        case (kind)
            K_CLK:   rd_val[CLK_W-1:0]  = clk_all[c*CLK_W +: CLK_W];
            K_CTRL:  rd_val[CTRL_W-1:0] = ctrl_all[c*CTRL_W +: CTRL_W];
            K_VALUE: rd_val[CNT_W-1:0]  = count_all[c*CNT_W +: CNT_W];
            K_INTV:  rd_val[CNT_W-1:0]  = intv_all[c*CNT_W +: CNT_W];
            K_M1, K_M2, K_M3: begin
                m = int'(kind) - int'(K_M1);
                rd_val[CNT_W-1:0] = match_all[(c*NMATCH + m)*CNT_W +: CNT_W];
            end
            K_STAT:  rd_val[STAT_W-1:0] = stat_all[c*STAT_W +: STAT_W];
            K_EN:    rd_val[STAT_W-1:0] = en_all[c*STAT_W +: STAT_W];
            K_EVC:   rd_val[EVC_W-1:0]  = evc_all[c*EVC_W +: EVC_W];
            K_EVENT: rd_val[CNT_W-1:0]  = event_all[c*CNT_W +: CNT_W];
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/tri_timer_regs.sv
// Top: register file for three timer channels with interleaved addressing
// (kind = word/3, channel = word%3), per-channel sticky interrupt status
// with clear-on-read, and one interrupt line per channel. Read data is
// registered. Assumes CNT_W <= DATA_W and that read and write strobes are
// not issued together.
module tri_timer_regs
    import ttr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NCH*CNT_W-1:0]          ch_count,
    input  logic [NCH*CNT_W-1:0]          ch_event,
    input  logic [NCH*STAT_W-1:0]         ch_strobe,
    output logic [NCH-1:0]                irq,
    output logic [NCH*CLK_W-1:0]          cfg_clkctl,
    output logic [NCH*CTRL_W-1:0]         cfg_cntctl,
    output logic [NCH*CNT_W-1:0]          cfg_interval,
    output logic [NCH*NMATCH*CNT_W-1:0]   cfg_match,
    output logic [NCH*EVC_W-1:0]          cfg_evctl
);
    localparam int unsigned CH_W = $clog2(NCH);

    kind_e               kind;
    logic [CH_W-1:0]     chan;
    logic [NCH*STAT_W-1:0] stat_all;
    logic [NCH*STAT_W-1:0] en_all;
    logic [DATA_W-1:0]   rd_val;

    ttr_decode #(
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .chan (chan)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic hit;
        assign hit = (kind != K_NONE) && (chan == CH_W'(c));

        ttr_chan #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_kind   (kind),
            .wr_hit    (bus_we && hit),
            .wdata     (bus_wdata),
            .clr_hit   (bus_re && hit && (kind == K_STAT)),
            .strobe    (ch_strobe[c*STAT_W +: STAT_W]),
            .clk_reg   (cfg_clkctl[c*CLK_W +: CLK_W]),
            .ctrl_reg  (cfg_cntctl[c*CTRL_W +: CTRL_W]),
            .intv_reg  (cfg_interval[c*CNT_W +: CNT_W]),
            .match_reg (cfg_match[c*NMATCH*CNT_W +: NMATCH*CNT_W]),
            .stat_reg  (stat_all[c*STAT_W +: STAT_W]),
            .en_reg    (en_all[c*STAT_W +: STAT_W]),
            .evc_reg   (cfg_evctl[c*EVC_W +: EVC_W]),
            .irq       (irq[c])
        );
    end

    ttr_rdmux #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) u_rdmux (
        .kind      (kind),
        .chan      (chan),
        .clk_all   (cfg_clkctl),
        .ctrl_all  (cfg_cntctl),
        .intv_all  (cfg_interval),
        .match_all (cfg_match),
        .stat_all  (stat_all),
        .en_all    (en_all),
        .evc_all   (cfg_evctl),
        .count_all (ch_count),
        .event_all (ch_event),
        .rd_val    (rd_val)
    );

    // Read data register: loads on a read strobe, otherwise holds
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/ttr_checker.sv
// Checker: temporal properties of the register file, bound to the top.
// Decodes addresses on its own from the bus pins.
module ttr_checker
    import ttr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic                   bus_re,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NCH*CNT_W-1:0]   ch_count,
    input logic [NCH*STAT_W-1:0]  ch_strobe,
    input logic [NCH*STAT_W-1:0]  stat_all,
    input logic [NCH*STAT_W-1:0]  en_all,
    input logic [NCH-1:0]         irq
);
    localparam int LIMIT     = int'(NCH * NKIND);
    localparam int STAT_BASE = int'(K_STAT) * int'(NCH);
    localparam int VAL_BASE  = int'(K_VALUE) * int'(NCH);

    int widx;
    assign widx = int'(bus_addr[ADDR_W-1:2]);

    // R5: every strobe bit is present in status one cycle later
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_strobe != '0) |=> ((stat_all & $past(ch_strobe)) == $past(ch_strobe)));

    // R9: unmapped reads return zero
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && widx >= LIMIT) |=> (bus_rdata == '0));

    // R10: read data holds without a read strobe
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    for (genvar c = 0; c < NCH; c++) begin : g_prop
        // R6: a status read with no strobe leaves the status empty
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && widx == STAT_BASE + c && ch_strobe[c*STAT_W +: STAT_W] == '0)
            |=> (stat_all[c*STAT_W +: STAT_W] == '0));

        // R7: after a status read only that cycle's strobes remain
        p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && widx == STAT_BASE + c)
            |=> (stat_all[c*STAT_W +: STAT_W] == $past(ch_strobe[c*STAT_W +: STAT_W])));

        // R8: an enabled strobe raises the line in the next cycle
        p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && (ch_strobe[c*STAT_W +: STAT_W] & en_all[c*STAT_W +: STAT_W]) != '0)
            |=> irq[c]);

        // R4: a count read returns the live input of that cycle
        p_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && widx == VAL_BASE + c)
            |=> (bus_rdata == DATA_W'($past(ch_count[c*CNT_W +: CNT_W]))));
    end
endmodule

bind tri_timer_regs ttr_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .ch_count  (ch_count),
    .ch_strobe (ch_strobe),
    .stat_all  (stat_all),
    .en_all    (en_all),
    .irq       (irq)
);

// File: tb/tri_timer_regs_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, judged
// against a register model kept in the bench.
module tri_timer_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic [47:0] ch_count;
    logic [47:0] ch_event;
    logic [17:0] ch_strobe;
    logic [2:0]  irq;
    logic [17:0] cfg_clkctl;
    logic [17:0] cfg_cntctl;
    logic [47:0] cfg_interval;
    logic [143:0] cfg_match;
    logic [8:0]  cfg_evctl;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] last_rd;

    logic [5:0]  m_clk [3];
    logic [5:0]  m_ctl [3];
    logic [15:0] m_int [3];
    logic [15:0] m_mat [3][3];
    logic [5:0]  m_sta [3];
    logic [5:0]  m_en  [3];
    logic [2:0]  m_evc [3];

    always #2.5 clk = ~clk;

    tri_timer_regs u_tri_timer_regs (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata),
        .ch_count (ch_count), .ch_event (ch_event), .ch_strobe (ch_strobe),
        .irq (irq), .cfg_clkctl (cfg_clkctl), .cfg_cntctl (cfg_cntctl),
        .cfg_interval (cfg_interval), .cfg_match (cfg_match), .cfg_evctl (cfg_evctl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int w = int'(a[7:2]);
        int k = w / 3;
        int c = w % 3;
        if (w >= 33) return 32'h0;
        case (k)
            0:  return 32'(m_clk[c]);
            1:  return 32'(m_ctl[c]);
            2:  return 32'(ch_count[c*16 +: 16]);
            3:  return 32'(m_int[c]);
            4, 5, 6: return 32'(m_mat[c][k-4]);
            7:  return 32'(m_sta[c]);
            8:  return 32'(m_en[c]);
            9:  return 32'(m_evc[c]);
            default: return 32'(ch_event[c*16 +: 16]);
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        int w = int'(a[7:2]);
        if (w >= 33) return "R9";
        if (w / 3 == 2 || w / 3 == 10) return "R4";
        if (w / 3 == 7) return "R6";
        return "R2/R3";
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        int w = int'(a[7:2]);
        int k = w / 3;
        int c = w % 3;
        if (w < 33) begin
            case (k)
                0: m_clk[c] = d[5:0];
                1: m_ctl[c] = d[5:0];
                3: m_int[c] = d[15:0];
                4, 5, 6: m_mat[c][k-4] = d[15:0];
                8: m_en[c]  = d[5:0];
                9: m_evc[c] = d[2:0];
                default: ;
            endcase
        end
    endtask

    // One bus cycle: drive at the falling edge, judge after the rising edge
    task automatic step(input logic we, input logic re, input logic [7:0] a,
                        input logic [31:0] d, input logic [17:0] stb, input string tag);
        logic [31:0] exp;
        int w;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; ch_strobe = stb;
        ch_count[31:0]  = $urandom; ch_count[47:32] = 16'($urandom);
        ch_event[31:0]  = $urandom; ch_event[47:32] = 16'($urandom);
        exp = exp_rd(a);
        @(posedge clk); #1;
        w = int'(a[7:2]);
        if (re) begin
            check(tag == "" ? req_of(a) : tag, bus_rdata, exp);
            last_rd = bus_rdata;
        end else begin
            check("R10 hold", bus_rdata, last_rd);
        end
        if (we) model_wr(a, d);
        if (re && w < 33 && w / 3 == 7) m_sta[w % 3] = '0;
        for (int c = 0; c < 3; c++) m_sta[c] |= stb[c*6 +: 6];
        for (int c = 0; c < 3; c++)
            check("R8 irq", 32'(irq[c]), 32'(|(m_sta[c] & m_en[c])));
    endtask

    task automatic chk_cfg(input string tag);
        for (int c = 0; c < 3; c++) begin
            check(tag, 32'(cfg_clkctl[c*6 +: 6]), 32'(m_clk[c]));
            check(tag, 32'(cfg_cntctl[c*6 +: 6]), 32'(m_ctl[c]));
            check(tag, 32'(cfg_interval[c*16 +: 16]), 32'(m_int[c]));
            check(tag, 32'(cfg_evctl[c*3 +: 3]), 32'(m_evc[c]));
            for (int m = 0; m < 3; m++)
                check(tag, 32'(cfg_match[(c*3+m)*16 +: 16]), 32'(m_mat[c][m]));
        end
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
        ch_strobe = 0; ch_count = 0; ch_event = 0; last_rd = 0;
        for (int c = 0; c < 3; c++) begin
            m_clk[c] = 0; m_ctl[c] = 6'h21; m_int[c] = 0; m_sta[c] = 0;
            m_en[c] = 0; m_evc[c] = 0;
            for (int m = 0; m < 3; m++) m_mat[c][m] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of lines, config and every mapped word
        @(posedge clk); #1;
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        chk_cfg("R1 cfg");
        for (int w = 0; w < 33; w++) step(0, 1, 8'(w*4), 0, 0, (w/3 == 2 || w/3 == 10) ? "R4" : "R1");

        // R2: per-channel interval and match writes land in their own channel
        for (int c = 0; c < 3; c++) step(1, 0, 8'(8'h24 + 4*c), 32'h1000 + c, 0, "");
        for (int c = 0; c < 3; c++)
            for (int m = 0; m < 3; m++) step(1, 0, 8'(8'h30 + 12*m + 4*c), 32'h5A00 + 16*m + c, 0, "");
        for (int c = 0; c < 3; c++) step(0, 1, 8'(8'h24 + 4*c), 0, 0, "R2");
        for (int m = 0; m < 3; m++) step(0, 1, 8'(8'h34 + 12*m), 0, 0, "R2");
        chk_cfg("R11 cfg");

        // R3: all-ones writes are masked to the field widths
        step(1, 0, 8'h00, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'h10, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'h28, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'h60, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'h74, 32'hFFFF_FFFF, 0, "");
        step(0, 1, 8'h00, 0, 0, "R3"); step(0, 1, 8'h10, 0, 0, "R3");
        step(0, 1, 8'h28, 0, 0, "R3"); step(0, 1, 8'h60, 0, 0, "R3");
        step(0, 1, 8'h74, 0, 0, "R3");

        // R4: writes to count and event words have no effect
        step(1, 0, 8'h18, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'h80, 32'hFFFF_FFFF, 0, "");
        step(0, 1, 8'h18, 0, 0, "R4"); step(0, 1, 8'h80, 0, 0, "R4");
        chk_cfg("R4 cfg");

        // R5/R8: enabled strobe raises irq0, disabled channel 1 stays low
        step(0, 0, 0, 0, 18'h00008 | 18'h00040, "");
        check("R5 irq0", 32'(irq[0]), 32'h1);
        check("R8 irq1", 32'(irq[1]), 32'h0);
        // R6: write to status is ignored, read returns and clears
        step(1, 0, 8'h54, 32'h0, 0, "");
        step(0, 1, 8'h54, 0, 0, "R6");
        check("R6 read", bus_rdata, 32'h08);
        step(0, 1, 8'h54, 0, 0, "R6");
        check("R6 cleared", bus_rdata, 32'h0);
        step(0, 1, 8'h58, 0, 0, "R6");
        check("R5 ch1 sticky", bus_rdata, 32'h01);

        // R7: strobe in the same cycle as the clearing read survives
        step(0, 0, 0, 0, 18'h00004, "");
        step(0, 1, 8'h54, 0, 18'h00001, "R7");
        check("R7 old value", bus_rdata, 32'h04);
        step(0, 1, 8'h54, 0, 0, "R7");
        check("R7 survivor", bus_rdata, 32'h01);

        // R9: unmapped words read zero and writes change nothing
        step(1, 0, 8'h84, 32'hFFFF_FFFF, 0, "");
        step(1, 0, 8'hFC, 32'hFFFF_FFFF, 0, "");
        step(0, 1, 8'h84, 0, 0, "R9"); step(0, 1, 8'hFC, 0, 0, "R9");
        chk_cfg("R9 cfg");
        step(0, 0, 0, 0, 0, "");

        // Random mix of reads, writes, idles and strobes
        for (int i = 0; i < 800; i++) begin
            int op = int'($urandom % 3);
            logic [7:0] a = 8'(($urandom % 40) * 4);
            logic [17:0] stb = ($urandom % 3 == 0) ? 18'($urandom) : 18'h0;
            if (op == 0) step(1, 0, a, $urandom, stb, "");
            else if (op == 1) step(0, 1, a, 0, stb, "");
            else step(0, 0, a, 0, stb, "");
        end
        step(0, 0, 0, 0, 0, "");
        chk_cfg("R11 cfg");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule